// File: doc/BRIEF.md
# Dense Vector Segment Broadcast Chain

This block takes a dense vector segment that arrives as a stream of wide words from one memory channel and gives every processing engine its own private copy of it. Each 512-bit input word carries sixteen 32-bit vector entries. A segment is 8192 entries, which is 512 input words. The words do not fan out from a single point. They travel down a linear chain of eight registered stages. Each stage writes the word into its own local row buffer and passes it to its neighbour on the next clock.

Input uses a valid/ready handshake. Once the final word of a segment has been accepted, the input stops accepting words. It stays closed while the tail of the chain finishes writing, and it stays closed while the segment-done flag waits for an acknowledge. After the acknowledge, a new segment may stream in and overwrite the buffers from row 0.

Each engine reads its copy through its own read port. The engine gives a 13-bit entry index. The upper nine bits select the buffer row and the lower four bits select the 32-bit lane within that row.

Top module: `vecseg_chain`

## Requirements
- R1: After reset, `in_ready` is high and `seg_done` is low.
- R2: Entry `16*w+i` of a segment is the 32-bit field at bits `[32*i+31:32*i]` of the w-th accepted input word of that segment. It is returned on stage 0's read port when index `16*w+i` is presented.
- R3: After a segment completes, each of the eight stages returns the same entry values as stage 0 for every index.
- R4: Stage n writes a given word exactly one clock after stage n-1 writes it. Stage 0 writes a word on the edge that accepts it at the input.
- R5: `seg_done` goes high on the 8th clock edge after the edge that accepts the 512th word of a segment, and not earlier.
- R6: `in_ready` is low from the edge that accepts the final word of a segment until the acknowledge is taken. Words offered while `in_ready` is low are not written to any buffer.
- R7: `seg_done` stays high until `seg_ack` is sampled high. `seg_ack` has no effect while `seg_done` is low.
- R8: On the edge where `seg_done` and `seg_ack` are both high, `seg_done` clears and `in_ready` returns high. The next segment then fills the buffers again from row 0.
- R9: Idle cycles (`in_valid` low) anywhere inside a segment do not change where any word is stored.
- R10: A read index is registered on a clock edge, and the selected entry appears on `rd_data` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Chain can accept an input word |
| in_data | input | 512 | Sixteen packed 32-bit vector entries, lane 0 in the low bits |
| seg_done | output | 1 | Whole segment is held in every stage |
| seg_ack | input | 1 | Acknowledges `seg_done` and opens the input for the next segment |
| rd_idx | input | 104 | Per-stage 13-bit entry index, stage s at bits `[13*s+12:13*s]` |
| rd_data | output | 256 | Per-stage 32-bit read entry, stage s at bits `[32*s+31:32*s]` |

## Verification
The hardest situation to reach from the ports is a word sitting partway down the chain: some stages have already written it and the rest still hold the previous segment's value. The stimulus creates this state on purpose. After a full first segment it accepts only word 0 of the second segment, then holds `in_valid` low. During that pause it reads index 0 on all eight ports each cycle and watches the new value move through the buffers one stage per clock. The drain window receives two kinds of stimulus. First, words are offered while `in_ready` is low, to check that they are rejected. Second, `seg_ack` is pulsed before `seg_done` rises. The later buffer reads show that neither of these events changed any buffer.

// File: rtl/vecseg_pkg.sv
package vecseg_pkg;

    // Default geometry of the chain
    localparam int unsigned DEF_LANES     = 16;
    localparam int unsigned DEF_ENTRY_W   = 32;
    localparam int unsigned DEF_SEG_WORDS = 512;
    localparam int unsigned DEF_STAGES    = 8;

    // Segment load control states
    typedef enum logic [1:0] {
        SEG_LOAD  = 2'd0,   // accepting input words
        SEG_DRAIN = 2'd1,   // final word in flight down the chain
        SEG_DONE  = 2'd2    // every stage holds the segment, waiting for ack
    } seg_state_e;

    // Width of the entry index for a given geometry
    function automatic int unsigned idx_width(input int unsigned words, input int unsigned lanes);
        return $clog2(words) + $clog2(lanes);
    endfunction

endpackage

// File: rtl/vecseg_feed.sv
module vecseg_feed
    import vecseg_pkg::*;
#(
    parameter int unsigned SEG_WORDS = DEF_SEG_WORDS
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic seg_ack,
    output logic seg_done,
    input  logic tail_vld,
    input  logic tail_lst,
    output logic head_vld,
    output logic head_lst
);
    localparam int unsigned AW = $clog2(SEG_WORDS);
    localparam logic [AW-1:0] LAST_WORD = AW'(SEG_WORDS - 1);

    seg_state_e     state_q;
    logic [AW-1:0]  cnt_q;
    logic           fire;
    logic           fire_last;

    assign in_ready  = (state_q == SEG_LOAD);
    assign seg_done  = (state_q == SEG_DONE);
    assign fire      = in_valid && in_ready;
    assign fire_last = fire && (cnt_q == LAST_WORD);
    assign head_vld  = fire;
    assign head_lst  = fire_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= fire_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEG_LOAD;
        end else begin
            unique case (state_q)
                SEG_LOAD:  if (fire_last)            state_q <= SEG_DRAIN;
                SEG_DRAIN: if (tail_vld && tail_lst) state_q <= SEG_DONE;
                SEG_DONE:  if (seg_ack)              state_q <= SEG_LOAD;
                default:                             state_q <= SEG_LOAD;
            endcase
        end
    end

endmodule

// File: rtl/vecseg_stage.sv
module vecseg_stage
    import vecseg_pkg::*;
#(
    parameter int unsigned LANES     = DEF_LANES,
    parameter int unsigned ENTRY_W   = DEF_ENTRY_W,
    parameter int unsigned SEG_WORDS = DEF_SEG_WORDS
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       in_vld,
    input  logic                                       in_lst,
    input  logic [LANES*ENTRY_W-1:0]                   in_data,
    output logic                                       out_vld,
    output logic                                       out_lst,
    output logic [LANES*ENTRY_W-1:0]                   out_data,
    input  logic [idx_width(SEG_WORDS, LANES)-1:0]     rd_idx,
    output logic [ENTRY_W-1:0]                         rd_data
);
    localparam int unsigned W    = LANES * ENTRY_W;
    localparam int unsigned AW   = $clog2(SEG_WORDS);
    localparam int unsigned LW   = $clog2(LANES);
    localparam int unsigned IDXW = AW + LW;

    logic [W-1:0]       rows [SEG_WORDS];
    logic [AW-1:0]      wptr_q;
    logic [W-1:0]       rd_row_q;
    logic [LW-1:0]      rd_lane_q;
    logic [ENTRY_W-1:0] lane_val [LANES];

    // Local row pointer follows the words this stage has written
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (in_vld) begin
            wptr_q <= in_lst ? '0 : wptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (in_vld) begin
            rows[wptr_q] <= in_data;
        end
    end

    // Register and forward to the next stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_lst <= 1'b0;
        end else begin
            out_vld <= in_vld;
            out_lst <= in_vld && in_lst;
        end
    end

    always_ff @(posedge clk) begin
        if (in_vld) begin
            out_data <= in_data;
        end
    end

    // Engine read port: row lookup, then lane select
    always_ff @(posedge clk) begin
        rd_row_q  <= rows[rd_idx[IDXW-1:LW]];
        rd_lane_q <= rd_idx[LW-1:0];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_val[g] = rd_row_q[g*ENTRY_W +: ENTRY_W];
    end

    assign rd_data = lane_val[rd_lane_q];

endmodule

// File: rtl/vecseg_chain.sv
module vecseg_chain
    import vecseg_pkg::*;
#(
    parameter int unsigned LANES     = DEF_LANES,
    parameter int unsigned ENTRY_W   = DEF_ENTRY_W,
    parameter int unsigned SEG_WORDS = DEF_SEG_WORDS,
    parameter int unsigned STAGES    = DEF_STAGES
) (
    input  logic                                              clk,
    input  logic                                              rst,
    input  logic                                              in_valid,
    output logic                                              in_ready,
    input  logic [LANES*ENTRY_W-1:0]                          in_data,
    output logic                                              seg_done,
    input  logic                                              seg_ack,
    input  logic [STAGES*idx_width(SEG_WORDS, LANES)-1:0]     rd_idx,
    output logic [STAGES*ENTRY_W-1:0]                         rd_data
);
    localparam int unsigned W    = LANES * ENTRY_W;
    localparam int unsigned IDXW = idx_width(SEG_WORDS, LANES);

    logic [STAGES:0] c_vld;
    logic [STAGES:0] c_lst;
    logic [W-1:0]    c_data [STAGES+1];
    logic [STAGES-1:0] stg_vld;
    logic [STAGES-1:0] stg_lst;

    vecseg_feed #(
        .SEG_WORDS (SEG_WORDS)
    ) u_feed (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .seg_ack  (seg_ack),
        .seg_done (seg_done),
        .tail_vld (c_vld[STAGES]),
        .tail_lst (c_lst[STAGES]),
        .head_vld (c_vld[0]),
        .head_lst (c_lst[0])
    );

    assign c_data[0] = in_data;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        vecseg_stage #(
            .LANES     (LANES),
            .ENTRY_W   (ENTRY_W),
            .SEG_WORDS (SEG_WORDS)
        ) u_stage (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (c_vld[s]),
            .in_lst   (c_lst[s]),
            .in_data  (c_data[s]),
            .out_vld  (c_vld[s+1]),
            .out_lst  (c_lst[s+1]),
            .out_data (c_data[s+1]),
            .rd_idx   (rd_idx[s*IDXW +: IDXW]),
            .rd_data  (rd_data[s*ENTRY_W +: ENTRY_W])
        );
    end

    // Registered forward flags of each stage, observed by the checker
    assign stg_vld = c_vld[STAGES:1];
    assign stg_lst = c_lst[STAGES:1];

endmodule

// File: rtl/vecseg_chain_chk.sv
module vecseg_chain_chk #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              seg_done,
    input logic              seg_ack,
    input logic [STAGES-1:0] stg_vld,
    input logic [STAGES-1:0] stg_lst
);

    AST_DONE_CLOSES_INPUT: assert property (@(posedge clk) disable iff (rst)
        seg_done |-> !in_ready); // R6

    AST_LAST_CLOSES_INPUT: assert property (@(posedge clk) disable iff (rst)
        (stg_vld[0] && stg_lst[0]) |-> !in_ready); // R6

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (seg_done && !seg_ack) |=> seg_done); // R7

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (seg_done && seg_ack) |=> (!seg_done && in_ready)); // R8

    AST_DONE_FROM_TAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(seg_done) |-> $past(stg_vld[STAGES-1] && stg_lst[STAGES-1])); // R5

    AST_HEAD_FROM_INPUT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> stg_vld[0]); // R4

    for (genvar n = 1; n < STAGES; n++) begin : g_step
        AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (rst)
            stg_vld[n-1] |=> stg_vld[n]); // R4

        AST_CHAIN_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
            !stg_vld[n-1] |=> !stg_vld[n]); // R4

        AST_LAST_STEP: assert property (@(posedge clk) disable iff (rst)
            (stg_vld[n-1] && stg_lst[n-1]) |=> stg_lst[n]); // R4
    end

endmodule

bind vecseg_chain vecseg_chain_chk #(
    .STAGES (STAGES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .seg_done (seg_done),
    .seg_ack  (seg_ack),
    .stg_vld  (stg_vld),
    .stg_lst  (stg_lst)
);

// File: tb/vecseg_chain_tb_top.sv
module vecseg_chain_tb_top;

    localparam int NST   = 8;
    localparam int NWD   = 512;
    localparam int NENT  = NWD * 16;
    localparam int IDXW  = 13;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [511:0]         in_data = '0;
    logic                 seg_done;
    logic                 seg_ack = 1'b0;
    logic [NST*IDXW-1:0]  rd_idx = '0;
    logic [NST*32-1:0]    rd_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    vecseg_chain dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .seg_done (seg_done),
        .seg_ack  (seg_ack),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    function automatic logic [31:0] ent(input logic [31:0] salt, input int idx);
        logic [31:0] v;
        v = 32'(idx) * 32'h9E3779B1;
        return v ^ salt;
    endfunction

    function automatic logic [511:0] word_of(input logic [31:0] salt, input int w);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = ent(salt, 16*w + i);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Stream one full segment; optional probe pause after word 0 (R4)
    task automatic drive_seg(input logic [31:0] salt, input logic [31:0] old_salt,
                             input int bubble_pct, input bit probe, input bit early_ack);
        int w = 0;
        while (w < NWD) begin
            @(negedge clk);
            if ($urandom_range(99) < bubble_pct) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_data  = word_of(salt, w);
                if (in_ready) begin
                    w++;
                    if (probe && w == 1) begin
                        for (int k = 1; k <= 10; k++) begin
                            @(negedge clk);
                            in_valid = 1'b0;
                            for (int s = 0; s < NST; s++) begin
                                logic [31:0] e;
                                e = (s + 2 <= k) ? ent(salt, 0) : ent(old_salt, 0);
                                chk(rd_data[s*32 +: 32] == e, "R4 chain write step", rd_data[s*32 +: 32], e);
                            end
                        end
                    end
                end
            end
        end
        // Drain window: final word accepted on the coming edge
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            in_valid = k[0];
            in_data  = {16{32'hDEAD_BEEF}};
            seg_ack  = (early_ack && k == 3);
            if (k <= 8) chk(in_ready == 1'b0, "R6 ready low in drain", 32'(in_ready), 32'd0);
            chk(seg_done == (k >= 9), "R5 done timing", 32'(seg_done), 32'(k >= 9));
        end
        seg_ack = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            chk(seg_done == 1'b1, "R7 done holds", 32'(seg_done), 32'd1);
            chk(in_ready == 1'b0, "R6 ready low while done", 32'(in_ready), 32'd0);
        end
        in_valid = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        seg_ack = 1'b1;
        @(negedge clk);
        seg_ack = 1'b0;
        chk(seg_done == 1'b0, "R8 ack clears done", 32'(seg_done), 32'd0);
        chk(in_ready == 1'b1, "R8 ack reopens input", 32'(in_ready), 32'd1);
    endtask

    task automatic check_reads(input logic [31:0] salt, input int n, input string tag);
        int idx [NST];
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            for (int s = 0; s < NST; s++) begin
                case (j)
                    0: idx[s] = 0;
                    1: idx[s] = NENT - 1;
                    2: idx[s] = 15;
                    3: idx[s] = 16;
                    default: idx[s] = int'($urandom_range(NENT - 1));
                endcase
                rd_idx[s*IDXW +: IDXW] = IDXW'(idx[s]);
            end
            @(negedge clk);
            for (int s = 0; s < NST; s++) begin
                logic [31:0] e;
                e = ent(salt, idx[s]);
                if (s == 0)
                    chk(rd_data[31:0] == e, {"R2 R10 lane mapping ", tag}, rd_data[31:0], e);
                else
                    chk(rd_data[s*32 +: 32] == e, {"R3 stage copy ", tag}, rd_data[s*32 +: 32], e);
            end
        end
        rd_idx = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [31:0] sa, sb, sc;
        void'($urandom(32'd1234));
        sa = $urandom(); sb = $urandom() | 32'h1; sc = $urandom();
        if (sb == sa) sb = sa ^ 32'h5555_0001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);
        chk(seg_done == 1'b0, "R1 reset done", 32'(seg_done), 32'd0);

        // R7: ack while idle is ignored
        seg_ack = 1'b1;
        @(negedge clk);
        seg_ack = 1'b0;
        chk(in_ready == 1'b1, "R7 idle ack ignored", 32'(in_ready), 32'd1);
        chk(seg_done == 1'b0, "R7 idle ack ignored", 32'(seg_done), 32'd0);

        // Segment A with random bubbles (R9)
        drive_seg(sa, 32'h0, 30, 1'b0, 1'b0);
        check_reads(sa, 24, "R9 bubbles seg A");
        do_ack();

        // Segment B: probe the chain step, early ack during drain (R4, R7)
        drive_seg(sb, sa, 0, 1'b1, 1'b1);
        check_reads(sb, 24, "R8 refill seg B");
        do_ack();

        // Segment C with heavy bubbles (R9)
        drive_seg(sc, sb, 60, 1'b0, 1'b0);
        check_reads(sc, 24, "R9 heavy bubbles seg C");
        do_ack();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule